// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block turns architectural general-register names into physical register indices for a 128-entry register file. The file has a fixed region and a rotating region. Names in the fixed region pass through unchanged. Names in the rotating region are shifted by a rotation base, and the result wraps inside that region. Because of this, each overlapped iteration of a software-pipelined loop gets fresh physical registers under the same names.

The base is held in a register and is driven by three controls: clear, load and step. A loop-control block outside this unit issues one step per iteration. Every step lowers the base by one. As a result, a value written under name r in one iteration is read under name r+1 in the next iteration.

All lookups are combinational. There are four read ports and two write ports, and each one resolves one name against the current base.

Top module: `rot_rename`

## Requirements
- R1: Names 0 to 31 map to the physical index equal to the name, whatever the base.
- R2: Names 32 to 127 map to physical index 32 + ((name − 32 + base) mod 96).
- R3: With a non-zero base, the physical index for name 127 is exactly one below the index for name 32. With base 1, name 127 maps to 32 and name 32 maps to 33.
- R4: While `rst_n` is low, and after it is released, the base is 0, so every name maps to itself.
- R5: `base_clear` high at a rising edge makes the base 0 from that edge on.
- R6: `base_load` high at a rising edge sets the base to `base_load_val` mod 96. For example, a load of 96 gives 0 and a load of 127 gives 31.
- R7: `rot_step` high at a rising edge lowers the base by one, and a base of 0 steps to 95. Lookups made in the cycle the step is requested still use the old base.
- R8: After one step, the physical index found under name r before the step is found under name r+1. Name 127 continues into name 32.
- R9: When several controls are high together, clear wins over load, and load wins over step.
- R10: All six lookup ports resolve independently and at the same time against the same base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets the base to 0 |
| base_clear | input | 1 | Set the base to 0 at the next edge |
| base_load | input | 1 | Load the base from `base_load_val` at the next edge |
| base_load_val | input | 7 | Base value to load, reduced mod 96 |
| rot_step | input | 1 | Lower the base by one at the next edge |
| rd_name | input | 28 | Four 7-bit read-port names; port k is at bits [7k+6:7k] |
| rd_phys | output | 28 | Four 7-bit physical indices, laid out the same way as `rd_name` |
| wr_name | input | 14 | Two 7-bit write-port names |
| wr_phys | output | 14 | Two 7-bit physical indices |

## Verification
A wrong base shows up on every rotating-name lookup on all six ports in the same cycle, one edge after the control that corrupted it. Static names do not reveal it. A bad wrap shows only at the boundaries: name 127 against name 32, a step from base 0, and loads of 96 or more. For that reason these cases are driven directly and checked right after the edge. A bad priority between controls shows as an index offset by the load value, or by one, on the first lookup after the colliding controls.

// File: rtl/rot_rename_pkg.sv
package rot_rename_pkg;
  // Base update selected each cycle, highest priority first in decode.
  typedef enum logic [1:0] {
    BOP_HOLD  = 2'd0,
    BOP_STEP  = 2'd1,
    BOP_LOAD  = 2'd2,
    BOP_CLEAR = 2'd3
  } base_op_e;
endpackage

// File: rtl/rrn_base_reg.sv
module rrn_base_reg
  import rot_rename_pkg::*;
#(
  parameter int ROT_REGS = 96,
  parameter int BASE_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [BASE_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [BASE_W-1:0] base_o
);
  localparam logic [BASE_W:0]   ROT_N   = ROT_REGS[BASE_W:0];
  localparam logic [BASE_W-1:0] ROT_TOP = ROT_REGS[BASE_W-1:0] - 1'b1;

  // Reduce a load value into the rotating range (one subtraction suffices
  // because 2**BASE_W < 2*ROT_REGS for the supported sizes).
  function automatic logic [BASE_W-1:0] clamp_base(input logic [BASE_W-1:0] v);
    logic [BASE_W:0] w;
    w = {1'b0, v};
    if (w >= ROT_N) w = w - ROT_N;
    return w[BASE_W-1:0];
  endfunction

  function automatic logic [BASE_W-1:0] step_base(input logic [BASE_W-1:0] b);
    return (b == '0) ? ROT_TOP : b - 1'b1;
  endfunction

  base_op_e        op;
  logic [BASE_W-1:0] base_q, base_d;
  logic            clear_fire, load_fire, step_fire;

  always_comb begin
    if (clear_i)      op = BOP_CLEAR;
    else if (load_i)  op = BOP_LOAD;
    else if (step_i)  op = BOP_STEP;
    else              op = BOP_HOLD;
  end

  assign clear_fire = (op == BOP_CLEAR);
  assign load_fire  = (op == BOP_LOAD);
  assign step_fire  = (op == BOP_STEP);

  always_comb begin
    unique case (op)
      BOP_CLEAR: base_d = '0;
      BOP_LOAD:  base_d = clamp_base(load_val_i);
      BOP_STEP:  base_d = step_base(base_q);
      default:   base_d = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign base_o = base_q;

  assert_base_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, base_q} < ROT_N);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (base_q == '0));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && (load_i || step_i)) |=> (base_q == '0));

  assert_load_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && (load_val_i < ROT_TOP) |=> (base_q == $past(load_val_i)));

  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && (base_q != '0) |=> (base_q + 1'b1 == $past(base_q)));

  assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && (base_q == '0) |=> (base_q == ROT_TOP));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i && !load_i && !step_i |=> $stable(base_q));
endmodule

// File: rtl/rrn_lookup.sv
module rrn_lookup #(
  parameter int STATIC_REGS = 32,
  parameter int ROT_REGS    = 96,
  parameter int IDX_W       = 7,
  parameter int BASE_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  name_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [IDX_W-1:0]  phys_o
);
  localparam logic [IDX_W:0]   STATIC_N = STATIC_REGS[IDX_W:0];
  localparam logic [IDX_W:0]   ROT_N    = ROT_REGS[IDX_W:0];
  localparam logic [IDX_W-1:0] STATIC_S = STATIC_REGS[IDX_W-1:0];

  // Offset into the rotating region, wrapped once (both terms < ROT_REGS).
  function automatic logic [IDX_W-1:0] remap(input logic [IDX_W-1:0] nm,
                                             input logic [BASE_W-1:0] b);
    logic [IDX_W:0] off;
    logic [IDX_W:0] bx;
    bx = '0;
    bx[BASE_W-1:0] = b;
    if ({1'b0, nm} < STATIC_N) return nm;
    off = {1'b0, nm} - STATIC_N + bx;
    if (off >= ROT_N) off = off - ROT_N;
    return off[IDX_W-1:0] + STATIC_S;
  endfunction

  logic is_static;
  assign is_static = ({1'b0, name_i} < STATIC_N);
  assign phys_o    = remap(name_i, base_i);

  assert_static_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_static |-> (phys_o == name_i));

  assert_rot_stays_rot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_static |-> ({1'b0, phys_o} >= STATIC_N));

  assert_zero_base_ident_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_i == '0) |-> (phys_o == name_i));
endmodule

// File: rtl/rot_rename.sv
module rot_rename #(
  parameter int STATIC_REGS = 32,
  parameter int ROT_REGS    = 96,
  parameter int RD_PORTS    = 4,
  parameter int WR_PORTS    = 2,
  localparam int PHYS_REGS  = STATIC_REGS + ROT_REGS,
  localparam int IDX_W      = $clog2(PHYS_REGS),
  localparam int BASE_W     = $clog2(ROT_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      base_clear,
  input  logic                      base_load,
  input  logic [BASE_W-1:0]         base_load_val,
  input  logic                      rot_step,
  input  logic [RD_PORTS*IDX_W-1:0] rd_name,
  output logic [RD_PORTS*IDX_W-1:0] rd_phys,
  input  logic [WR_PORTS*IDX_W-1:0] wr_name,
  output logic [WR_PORTS*IDX_W-1:0] wr_phys
);
  logic [BASE_W-1:0] cur_base;

  rrn_base_reg #(.ROT_REGS(ROT_REGS), .BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .clear_i(base_clear), .load_i(base_load),
    .load_val_i(base_load_val), .step_i(rot_step), .base_o(cur_base)
  );

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    rrn_lookup #(.STATIC_REGS(STATIC_REGS), .ROT_REGS(ROT_REGS),
                 .IDX_W(IDX_W), .BASE_W(BASE_W)) u_map (
      .clk(clk), .rst_n(rst_n), .name_i(rd_name[g*IDX_W +: IDX_W]),
      .base_i(cur_base), .phys_o(rd_phys[g*IDX_W +: IDX_W])
    );
  end

  for (genvar g = 0; g < WR_PORTS; g++) begin : g_wr
    rrn_lookup #(.STATIC_REGS(STATIC_REGS), .ROT_REGS(ROT_REGS),
                 .IDX_W(IDX_W), .BASE_W(BASE_W)) u_map (
      .clk(clk), .rst_n(rst_n), .name_i(wr_name[g*IDX_W +: IDX_W]),
      .base_i(cur_base), .phys_o(wr_phys[g*IDX_W +: IDX_W])
    );
  end

  // Same name on two ports must resolve identically (shared base).
  assert_ports_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_name[IDX_W-1:0] == wr_name[IDX_W-1:0]) |-> (rd_phys[IDX_W-1:0] == wr_phys[IDX_W-1:0]));
endmodule

// File: tb/rot_rename_tb.sv
module rot_rename_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_clear = 1'b0, base_load = 1'b0, rot_step = 1'b0;
  logic [6:0]  base_load_val = '0;
  logic [27:0] rd_name = '0;
  logic [27:0] rd_phys;
  logic [13:0] wr_name = '0;
  logic [13:0] wr_phys;

  int n_chk = 0, n_bad = 0, mbase = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  rot_rename u_dut (.*);

  // op: 0 hold, 1 step, 2 load, 3 clear ; {op, value}
  localparam logic [8:0] VEC [16] = '{
    {2'd3, 7'd0}, {2'd1, 7'd0}, {2'd1, 7'd0}, {2'd2, 7'd10},
    {2'd1, 7'd0}, {2'd2, 7'd95}, {2'd2, 7'd96}, {2'd2, 7'd127},
    {2'd1, 7'd0}, {2'd0, 7'd0}, {2'd3, 7'd0}, {2'd1, 7'd0},
    {2'd2, 7'd1}, {2'd1, 7'd0}, {2'd1, 7'd0}, {2'd2, 7'd50}};

  // Independent restatement: name-32+96 == name+64.
  function automatic int expect_phys(int nm, int b);
    if (nm < 32) return nm;
    return 32 + ((nm + b + 64) % 96);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_names(int a, int b, int c, int d, int e, int f);
    rd_name = {7'(d), 7'(c), 7'(b), 7'(a)};
    wr_name = {7'(f), 7'(e)};
  endtask

  task automatic check_all(string tag);
    #1;
    for (int k = 0; k < 4; k++)
      chk(tag, int'(rd_phys[k*7 +: 7]), expect_phys(int'(rd_name[k*7 +: 7]), mbase));
    for (int k = 0; k < 2; k++)
      chk(tag, int'(wr_phys[k*7 +: 7]), expect_phys(int'(wr_name[k*7 +: 7]), mbase));
  endtask

  task automatic apply(int op, int val);
    @(negedge clk);
    rot_step = (op == 1); base_load = (op == 2); base_clear = (op == 3);
    base_load_val = 7'(val);
    @(posedge clk); #1;
    rot_step = 0; base_load = 0; base_clear = 0;
    if (op == 3) mbase = 0;
    else if (op == 2) mbase = val % 96;
    else if (op == 1) mbase = (mbase + 95) % 96;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R4: identity in and after reset
    set_names(0, 31, 32, 127, 64, 100);
    #1; chk("R4 in reset", int'(rd_phys[27:21]), 127);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); check_all("R4 after reset");

    // Vector table: R1/R2 on all ports, R5/R6/R7 per op, R10 six ports at once
    for (int i = 0; i < 16; i++) begin
      int op, val;
      op  = int'(VEC[i][8:7]);
      val = int'(VEC[i][6:0]);
      apply(op, val);
      @(negedge clk);
      set_names((i*37 + 5) % 128, (i*11) % 32, 32 + (i*29) % 96,
                127 - i, 32 + i, (i*53 + 40) % 128);
      check_all(op == 3 ? "R5 clear" : op == 2 ? "R6 load" :
                op == 1 ? "R7 step" : "R2 hold R10 ports");
    end

    // R3: wraparound with base 1
    apply(2, 1);
    @(negedge clk); set_names(127, 32, 5, 126, 127, 32);
    #1;
    chk("R3 name127", int'(rd_phys[6:0]), 32);
    chk("R3 name32", int'(rd_phys[13:7]), 33);
    chk("R3 adjacency", int'(wr_phys[6:0]) + 1, int'(wr_phys[13:7]));
    chk("R1 static under base 1", int'(rd_phys[20:14]), 5);

    // R7: same-cycle lookup uses old base; step from 0 wraps to 95
    apply(3, 0);
    @(negedge clk);
    rot_step = 1; set_names(40, 127, 32, 0, 50, 96);
    #1; chk("R7 old base same cycle", int'(rd_phys[6:0]), 40);
    @(posedge clk); #1; rot_step = 0; mbase = 95;
    @(negedge clk); check_all("R7 wrap 0 to 95");

    // R8: value under r found under r+1 after a step
    apply(2, 20);
    begin
      int p40, p127;
      @(negedge clk); set_names(40, 127, 90, 31, 64, 33); #1;
      p40 = int'(rd_phys[6:0]); p127 = int'(rd_phys[13:7]);
      apply(1, 0);
      @(negedge clk); set_names(41, 32, 91, 31, 65, 34); #1;
      chk("R8 name 40->41", int'(rd_phys[6:0]), p40);
      chk("R8 name 127->32", int'(rd_phys[13:7]), p127);
    end

    // R9: priority between controls
    apply(2, 30);
    @(negedge clk);
    base_clear = 1; base_load = 1; base_load_val = 7'd70; rot_step = 1;
    @(posedge clk); #1; base_clear = 0; base_load = 0; rot_step = 0; mbase = 0;
    @(negedge clk); set_names(32, 60, 127, 10, 33, 80);
    check_all("R9 clear over load and step");
    @(negedge clk);
    base_load = 1; base_load_val = 7'd100; rot_step = 1;
    @(posedge clk); #1; base_load = 0; rot_step = 0; mbase = 4;
    @(negedge clk); check_all("R9 load over step");
    #1; chk("R9 load 100 on name 32", int'(rd_phys[6:0]), 36);

    // R4: mid-run reset returns to identity
    @(negedge clk); rst_n = 1'b0; mbase = 0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); set_names(32, 127, 95, 64, 100, 33);
    check_all("R4 mid-run reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule